// File: doc/BRIEF.md
# Flags Register Push Unit

This unit carries out the one-byte "push flags" instruction of a 32-bit x86-style core. It takes a start pulse together with the decoded opcode, the operand-size attribute, the stack-size attribute, the current flags word and the current stack pointer. It then does one of two things. It raises a general-protection fault with no side effects, or it issues exactly one stack write and returns the decremented stack pointer.

The operand-size attribute alone sets the width of the push. A 32-bit push stores a masked 32-bit image of the flags. The resume and virtual-8086 bits and the top byte of that image are forced to zero. A 16-bit push stores only the low half of the flags. When the virtual-8086 bit is set in the incoming flags, a privilege check on the I/O privilege field decides whether the push may proceed.

The write goes out on a simple request/ready port. The new stack pointer and the done pulse appear only after the port has accepted the write.

Top module: `flagpush_unit`

## Requirements
- R1: After reset, done_o, fault_o and mem_req_o are 0 and sp_o is 0.
- R2: A start pulse is acted on only when opcode_i equals 0x9C. With any other opcode, no request, no done and no fault follow.
- R3: With opsize32_i=1, the new stack pointer is the old one minus 4, the write address is the new stack pointer, and mem_be_o is 4'b1111.
- R4: A 32-bit push writes flags_i AND 0x00FCFFFF. Bits 16 and 17 and bits 31:24 of the written word are zero, and all other bits copy flags_i.
- R5: With opsize32_i=0, the stack pointer drops by 2 and only flags_i[15:0] is written. If address bit 1 is 0, mem_be_o=4'b0011 and the data sits in bits 15:0. If address bit 1 is 1, mem_be_o=4'b1100 and the data sits in bits 31:16.
- R6: When flags_i bit 17 (virtual-8086 mode) is 0, the push proceeds for every value of flags_i bits 13:12.
- R7: When flags_i bit 17 is 1 and flags_i bits 13:12 (I/O privilege level) are below 3, the cycle after start shows done_o=1 and fault_o=1 together. In that cycle no write is requested and sp_o equals the sp_i given with start.
- R8: When flags_i bit 17 is 1 and bits 13:12 equal 3, the push behaves exactly as in R3/R4 or R5 for the chosen operand size.
- R9: With stack32_i=0, only sp bits 15:0 are decremented, wrapping modulo 2^16, and bits 31:16 are kept.
- R10: mem_req_o rises the cycle after an accepted start. It holds with stable address, data and enables until a cycle with mem_ready_i=1. In the next cycle done_o pulses for one cycle, sp_o shows the new stack pointer, and mem_req_o is 0.
- R11: Start pulses that arrive while a write is outstanding are ignored. They change neither the pending write nor the final stack pointer, and they launch no later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| opcode_i | input | 8 | Decoded opcode byte |
| opsize32_i | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| stack32_i | input | 1 | 1 = 32-bit stack pointer, 0 = 16-bit |
| flags_i | input | 32 | Current flags word |
| sp_i | input | 32 | Current stack pointer |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | General-protection fault, valid with done_o |
| mem_req_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data, little-endian |
| mem_be_o | output | 4 | Byte enables |
| mem_ready_i | input | 1 | Write accepted this cycle |
| sp_o | output | 32 | Updated stack pointer |

## Verification
An all-ones flags word with the virtual-8086 bit set and privilege 3 shows whether the mask clears exactly bits 16, 17 and 31:24, and whether the privilege check passes at level 3. A sparse flags word with the mode bit clear and a low privilege level shows that privilege is checked only in virtual-8086 mode, and levels 0, 1 and 2 with the mode bit set must each fault without a write. For 16-bit pushes, stack pointers that differ in address bit 1 pick out the two byte lanes. For a 16-bit stack, pointers near zero tell a 16-bit wrap apart from a borrow into the upper half. A delayed ready with a stray start in the middle shows whether the commit waits for acceptance and whether the pending write is protected.

// File: rtl/flagpush_pkg.sv
package flagpush_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned BE_W      = XLEN / 8;
  localparam int unsigned HALF      = XLEN / 2;
  localparam int unsigned VM_BIT    = 17;
  localparam int unsigned PL_LO     = 12;
  localparam logic [XLEN-1:0] IMG_MASK = 32'h00FC_FFFF;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} fp_state_e;

  // Image stored for a 32-bit push: mode and resume bits cleared.
  function automatic logic [XLEN-1:0] flags_image(input logic [XLEN-1:0] f);
    return f & IMG_MASK;
  endfunction

  // Stack pointer after the push, honouring the stack-size attribute.
  function automatic logic [XLEN-1:0] sp_after(input logic [XLEN-1:0] sp,
                                               input logic op32, input logic st32);
    logic [HALF-1:0] lo;
    logic [XLEN-1:0] dec;
    dec = op32 ? XLEN'(4) : XLEN'(2);
    lo  = sp[HALF-1:0] - dec[HALF-1:0];
    if (st32) return sp - dec;
    return {sp[XLEN-1:HALF], lo};
  endfunction

  function automatic logic [BE_W-1:0] lane_enables(input logic op32, input logic a1);
    if (op32) return '1;
    return a1 ? 4'b1100 : 4'b0011;
  endfunction

  function automatic logic [XLEN-1:0] place_data(input logic op32, input logic a1,
                                                 input logic [XLEN-1:0] f);
    if (op32) return flags_image(f);
    return a1 ? {f[HALF-1:0], {HALF{1'b0}}} : {{HALF{1'b0}}, f[HALF-1:0]};
  endfunction
endpackage

// File: rtl/flagpush_guard.sv
module flagpush_guard
  import flagpush_pkg::*;
(
  input  logic [XLEN-1:0] flags_i,
  output logic            fault_o
);
  logic       vm_w;
  logic [1:0] iopl_w;
  assign vm_w    = flags_i[VM_BIT];
  assign iopl_w  = flags_i[PL_LO+1:PL_LO];
  assign fault_o = vm_w && (iopl_w != 2'd3);
endmodule

// File: rtl/flagpush_datapath.sv
module flagpush_datapath
  import flagpush_pkg::*;
(
  input  logic            op32_i,
  input  logic            st32_i,
  input  logic [XLEN-1:0] flags_i,
  input  logic [XLEN-1:0] sp_i,
  output logic [XLEN-1:0] new_sp_o,
  output logic [XLEN-1:0] wdata_o,
  output logic [BE_W-1:0] be_o
);
  always_comb begin
    new_sp_o = sp_after(sp_i, op32_i, st32_i);
    wdata_o  = place_data(op32_i, new_sp_o[1], flags_i);
    be_o     = lane_enables(op32_i, new_sp_o[1]);
  end
endmodule

// File: rtl/flagpush_unit.sv
module flagpush_unit
  import flagpush_pkg::*;
#(
  parameter logic [7:0] OPCODE = 8'h9C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [7:0]      opcode_i,
  input  logic            opsize32_i,
  input  logic            stack32_i,
  input  logic [31:0]     flags_i,
  input  logic [31:0]     sp_i,
  output logic            done_o,
  output logic            fault_o,
  output logic            mem_req_o,
  output logic [31:0]     mem_addr_o,
  output logic [31:0]     mem_wdata_o,
  output logic [3:0]      mem_be_o,
  input  logic            mem_ready_i,
  output logic [31:0]     sp_o
);
  fp_state_e       state_q;
  logic            accept_w, handshake_w, deny_w;
  logic [XLEN-1:0] nsp_w, wdata_w;
  logic [BE_W-1:0] be_w;
  logic [XLEN-1:0] addr_q, data_q;
  logic [BE_W-1:0] be_q;

  flagpush_guard u_guard (.flags_i(flags_i), .fault_o(deny_w));

  flagpush_datapath u_dp (
    .op32_i(opsize32_i), .st32_i(stack32_i), .flags_i(flags_i), .sp_i(sp_i),
    .new_sp_o(nsp_w), .wdata_o(wdata_w), .be_o(be_w)
  );

  assign accept_w    = start_i && (opcode_i == OPCODE) && (state_q == ST_IDLE);
  assign handshake_w = (state_q == ST_WAIT) && mem_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      sp_o    <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      if (accept_w && deny_w) begin
        done_o  <= 1'b1;
        fault_o <= 1'b1;
        sp_o    <= sp_i;
      end else if (accept_w) begin
        state_q <= ST_WAIT;
        addr_q  <= nsp_w;
        data_q  <= wdata_w;
        be_q    <= be_w;
      end else if (handshake_w) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
        sp_o    <= addr_q;
      end
    end
  end

  assign mem_req_o   = (state_q == ST_WAIT);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;
  assign mem_be_o    = be_q;

  a_r7_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o && !mem_req_o);
  a_r7_fault_keeps_sp: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> sp_o == $past(sp_i));
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_wdata_o) && $stable(mem_be_o));
  a_r10_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o |-> $past(mem_req_o && mem_ready_i) && !mem_req_o);
  a_r4_mask_bits: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_be_o == 4'hF |-> mem_wdata_o[31:24] == 8'h0 && mem_wdata_o[17:16] == 2'b00);
  a_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == 2 || $countones(mem_be_o) == 4));
endmodule

// File: tb/flagpush_unit_bench.sv
`timescale 1ns/1ps
module flagpush_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        opsize32_i = 1'b1;
  logic        stack32_i = 1'b1;
  logic [31:0] flags_i = '0;
  logic [31:0] sp_i = '0;
  logic        mem_ready_i = 1'b0;
  logic        done_o, fault_o, mem_req_o;
  logic [31:0] mem_addr_o, mem_wdata_o, sp_o;
  logic [3:0]  mem_be_o;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  flagpush_unit u_flagpush_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .opsize32_i(opsize32_i), .stack32_i(stack32_i), .flags_i(flags_i), .sp_i(sp_i),
    .done_o(done_o), .fault_o(fault_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_be_o(mem_be_o), .mem_ready_i(mem_ready_i), .sp_o(sp_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] opc, input logic op32, input logic st32,
                        input logic [31:0] fl, input logic [31:0] sp);
    @(negedge clk);
    start_i = 1'b1; opcode_i = opc; opsize32_i = op32; stack32_i = st32;
    flags_i = fl; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0; sp_i = 32'hDEAD_BEEF; flags_i = '0;
  endtask

  // Successful push; expectations written from the requirements.
  task automatic push_ok(input string tag, input logic op32, input logic st32,
                         input logic [31:0] fl, input logic [31:0] sp,
                         input int delay, input bit stray);
    logic [31:0] esp, edata;
    logic [3:0]  ebe;
    logic [15:0] lo;
    lo  = sp[15:0] - (op32 ? 16'd4 : 16'd2);
    esp = st32 ? sp - (op32 ? 32'd4 : 32'd2) : {sp[31:16], lo};
    if (op32) begin
      edata = {8'h00, fl[23:18], 2'b00, fl[15:0]};
      ebe   = 4'b1111;
    end else if (esp[1]) begin
      edata = {fl[15:0], 16'h0000}; ebe = 4'b1100;
    end else begin
      edata = {16'h0000, fl[15:0]}; ebe = 4'b0011;
    end
    launch(8'h9C, op32, st32, fl, sp);
    chk({tag, " R10 req"}, 32'(mem_req_o), 1);
    chk({tag, " addr"}, mem_addr_o, esp);
    chk({tag, " data"}, mem_wdata_o, edata);
    chk({tag, " be"}, 32'(mem_be_o), 32'(ebe));
    for (int i = 0; i < delay; i++) begin
      if (stray && i == 0) begin
        start_i = 1'b1; opcode_i = 8'h9C; flags_i = 32'h0000_0002; sp_i = 32'h0000_5000;
      end
      @(negedge clk);
      start_i = 1'b0;
      chk({tag, " R10 held"}, {mem_req_o, done_o}, 32'h2);
      chk({tag, " R11 addr kept"}, mem_addr_o, esp);
    end
    mem_ready_i = 1'b1;
    @(negedge clk);
    mem_ready_i = 1'b0;
    chk({tag, " R10 done"}, {done_o, fault_o, mem_req_o}, 32'h4);
    chk({tag, " R10 sp"}, sp_o, esp);
    @(negedge clk);
    chk({tag, " R10 pulse/R11 no relaunch"}, {done_o, mem_req_o}, 32'h0);
  endtask

  task automatic push_fault(input string tag, input logic [31:0] fl, input logic [31:0] sp);
    launch(8'h9C, 1'b1, 1'b1, fl, sp);
    chk({tag, " R7 done+fault"}, {done_o, fault_o, mem_req_o}, 32'h6);
    chk({tag, " R7 sp"}, sp_o, sp);
    @(negedge clk);
    chk({tag, " R7 quiet"}, {done_o, fault_o, mem_req_o}, 32'h0);
  endtask

  task automatic wrong_opcode();
    launch(8'h9D, 1'b1, 1'b1, 32'h0000_0202, 32'h0000_3000);
    for (int i = 0; i < 3; i++) begin
      chk("R2 ignored", {done_o, fault_o, mem_req_o}, 32'h0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {done_o, fault_o, mem_req_o}, 32'h0);
    chk("R1 reset sp", sp_o, 32'h0);
    rst_n = 1'b1;
    push_ok("R8 R4 R3 vm iopl3", 1'b1, 1'b1, 32'hFFFF_FFFF, 32'h0000_1000, 0, 1'b0);
    push_ok("R6 R3 vm0 iopl1", 1'b1, 1'b1, 32'h0000_1202, 32'h0000_1000, 1, 1'b0);
    push_ok("R5 hi lane", 1'b0, 1'b1, 32'h1234_A5C3, 32'h0000_2000, 0, 1'b0);
    push_ok("R5 lo lane", 1'b0, 1'b1, 32'h1234_A5C3, 32'h0000_2002, 0, 1'b0);
    push_ok("R8 R5 vm iopl3 16", 1'b0, 1'b1, 32'h0002_3001, 32'h0000_0104, 0, 1'b0);
    for (int l = 0; l < 3; l++)
      push_fault("R7 level", 32'h0002_0002 | (32'(l) << 12), 32'h0000_0800 + 32'(l));
    push_ok("R9 wrap 32op", 1'b1, 1'b0, 32'h0000_0046, 32'hABCD_0000, 0, 1'b0);
    push_ok("R9 wrap 16op", 1'b0, 1'b0, 32'h0000_0046, 32'h1234_0001, 0, 1'b0);
    push_ok("R9 no wrap", 1'b1, 1'b0, 32'h0000_0046, 32'h1234_8000, 0, 1'b0);
    wrong_opcode();
    push_ok("R10 R11 delayed", 1'b1, 1'b1, 32'h0000_0ED7, 32'h0000_4000, 4, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule